// File: doc/BRIEF.md
# Stack Expression Evaluator

This block executes postfix arithmetic on a register stack. Each instruction carries a 2-bit operation code and a memory address. Two operations move data between a small word memory and the stack: a load onto the stack and a store from the top of the stack. The other two operations, add and multiply, have no operand address. They take the two uppermost stack entries and replace them with one result. A postfix program that loads the operands, combines them and stores the last value therefore computes a whole expression without naming any intermediate location.

Instructions arrive on a valid/ready handshake. Each accepted instruction occupies the unit for two clock edges. The unit reports the stack depth, the top entry and two sticky error flags. One flag records a load attempted on a full stack and the other records an operation that had too few entries. A separate memory port lets the surrounding logic write operand words and read results. Reset clears the depth and the flags. It does not clear the memory contents.

Top module: `stack_eval`

## Requirements
- R1: After reset the stack depth is 0 (empty), the top output is 0, both error flags are 0 and `instr_ready` is 1.
- R2: An instruction is taken on a rising edge where `instr_valid` and `instr_ready` are both 1. `instr_ready` is 0 for the following cycle. The instruction's effect is visible after the second rising edge, and `instr_ready` is 1 again at that point.
- R3: Operation code 00 (load) copies the memory word at `instr_addr` onto the stack, raises the depth by one and makes that word the top output.
- R4: Operation code 01 (store) writes the top entry to the memory word at `instr_addr` and lowers the depth by one.
- R5: Operation code 10 (add) replaces the two uppermost entries with their sum, kept modulo 2^DATA_W, and lowers the depth by one. The address field has no effect.
- R6: Operation code 11 (multiply) replaces the two uppermost entries with the low DATA_W bits of their product and lowers the depth by one.
- R7: A load while DEPTH entries are held sets `overflow`. The depth and the top entry stay unchanged, and `overflow` stays set until reset.
- R8: A store with no entries held, or an add or multiply with fewer than two entries held, sets `underflow`. The stack and the memory stay unchanged, and `underflow` stays set until reset.
- R9: The program load A, load B, add, load C, load D, add, multiply, store X leaves (A+B)*(C+D) in memory word X and an empty stack.
- R10: When `mem_we` is 1, the memory port writes `mem_wdata` to word `mem_addr` on the rising edge. `mem_rdata` always shows the word at `mem_addr` without a clock delay. A store instruction that is executing takes priority over the port write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can take an instruction |
| instr_op | input | 2 | Operation: 00 load, 01 store, 10 add, 11 multiply |
| instr_addr | input | AW | Memory word for load and store |
| mem_we | input | 1 | Memory port write enable |
| mem_addr | input | AW | Memory port address |
| mem_wdata | input | DATA_W | Memory port write data |
| mem_rdata | output | DATA_W | Word at mem_addr |
| stack_ptr | output | CW | Number of entries held |
| stack_top | output | DATA_W | Top entry, 0 when empty |
| overflow | output | 1 | Sticky full-stack error |
| underflow | output | 1 | Sticky too-few-entries error |

## Verification
An instruction offered before rising edge N is accepted at N. `instr_ready` is low between N and N+1. The stack depth, the top entry, the flags and any memory write change at edge N+1. The bench drives inputs on falling edges and samples the busy state on the falling edge after acceptance. It samples results on the falling edge after the second rising edge, so every check falls exactly one half cycle after the edge that produces the value. Memory reads through the port are combinational, so the bench samples them one delay step after setting the address while the unit is idle.

// File: rtl/stack_eval_pkg.sv
package stack_eval_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_ADD   = 2'b10,
      OP_MUL   = 2'b11
   } op_e;
endpackage

// File: rtl/stack_eval_alu.sv
module stack_eval_alu #(
   parameter int DATA_W       = 16,
   parameter bit WIDE_PRODUCT = 1'b0
) (
   input  logic              is_mul,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] prod;

   generate
      if (WIDE_PRODUCT) begin : g_wide
         logic [2*DATA_W-1:0] full;
         assign full = {{DATA_W{1'b0}}, opa} * {{DATA_W{1'b0}}, opb};
         assign prod = full[DATA_W-1:0];
      end else begin : g_narrow
         assign prod = opa * opb;
      end
   endgenerate

   always_comb begin
      if (is_mul) result = prod;
      else        result = opa + opb;
   end
endmodule

// File: rtl/stack_eval_stack.sv
module stack_eval_stack #(
   parameter int  DATA_W = 16,
   parameter int  DEPTH  = 32,
   localparam int CW     = $clog2(DEPTH + 1),
   localparam int IW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              merge,
   input  logic [DATA_W-1:0] push_data,
   input  logic [DATA_W-1:0] merge_data,
   output logic [CW-1:0]     count,
   output logic [DATA_W-1:0] top,
   output logic [DATA_W-1:0] second
);
   logic [DATA_W-1:0] ent [DEPTH];
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     i_new, i_top, i_sec;

   assign i_new = IW'(cnt);
   assign i_top = IW'(cnt - CW'(1));
   assign i_sec = IW'(cnt - CW'(2));

   always_ff @(posedge clk) begin
      if (push)       ent[i_new] <= push_data;
      else if (merge) ent[i_sec] <= merge_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (push)           cnt <= cnt + CW'(1);
      else if (pop || merge)   cnt <= cnt - CW'(1);
   end

   assign count  = cnt;
   assign top    = (cnt == '0)     ? '0 : ent[i_top];
   assign second = (cnt < CW'(2))  ? '0 : ent[i_sec];
endmodule

// File: rtl/stack_eval_dmem.sv
module stack_eval_dmem #(
   parameter int  DATA_W = 16,
   parameter int  WORDS  = 16,
   localparam int AW     = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] words [WORDS];

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= wdata;
   end

   assign rdata_a = words[raddr_a];
   assign rdata_b = words[raddr_b];
endmodule

// File: rtl/stack_eval.sv
module stack_eval
   import stack_eval_pkg::*;
#(
   parameter int  DATA_W       = 16,
   parameter int  DEPTH        = 32,
   parameter int  MEM_WORDS    = 16,
   parameter bit  WIDE_PRODUCT = 1'b0,
   localparam int AW           = $clog2(MEM_WORDS),
   localparam int CW           = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   output logic              instr_ready,
   input  logic [1:0]        instr_op,
   input  logic [AW-1:0]     instr_addr,
   input  logic              mem_we,
   input  logic [AW-1:0]     mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] mem_rdata,
   output logic [CW-1:0]     stack_ptr,
   output logic [DATA_W-1:0] stack_top,
   output logic              overflow,
   output logic              underflow
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("stack_eval: DEPTH must be a power of two and at least 2");
      end
      if (MEM_WORDS < 2 || (MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_words
         $error("stack_eval: MEM_WORDS must be a power of two and at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("stack_eval: DATA_W must be positive");
      end
   endgenerate

   logic          busy_q;
   op_e           op_q;
   logic [AW-1:0] addr_q;
   logic          accept;

   logic [CW-1:0]     count;
   logic [DATA_W-1:0] top, second, load_word, alu_res;
   logic              do_push, do_pop, do_merge, set_ovf, set_udf;
   logic              is_arith, full, empty;
   logic              dm_we;
   logic [AW-1:0]     dm_waddr;
   logic [DATA_W-1:0] dm_wdata;

   assign instr_ready = !busy_q;
   assign accept      = instr_valid && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= OP_LOAD;
         addr_q <= '0;
      end else begin
         busy_q <= accept;
         if (accept) begin
            op_q   <= op_e'(instr_op);
            addr_q <= instr_addr;
         end
      end
   end

   assign full     = (count == CW'(DEPTH));
   assign empty    = (count == '0);
   assign is_arith = (op_q == OP_ADD) || (op_q == OP_MUL);

   always_comb begin
      do_push  = busy_q && (op_q == OP_LOAD)  && !full;
      set_ovf  = busy_q && (op_q == OP_LOAD)  &&  full;
      do_pop   = busy_q && (op_q == OP_STORE) && !empty;
      do_merge = busy_q && is_arith && (count >= CW'(2));
      set_udf  = busy_q && (((op_q == OP_STORE) && empty) ||
                            (is_arith && (count < CW'(2))));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         if (set_ovf) overflow  <= 1'b1;
         if (set_udf) underflow <= 1'b1;
      end
   end

   assign dm_we    = do_pop || mem_we;
   assign dm_waddr = do_pop ? addr_q : mem_addr;
   assign dm_wdata = do_pop ? top    : mem_wdata;

   stack_eval_dmem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_dmem (
      .clk     (clk),
      .we      (dm_we),
      .waddr   (dm_waddr),
      .wdata   (dm_wdata),
      .raddr_a (addr_q),
      .rdata_a (load_word),
      .raddr_b (mem_addr),
      .rdata_b (mem_rdata)
   );

   stack_eval_alu #(.DATA_W(DATA_W), .WIDE_PRODUCT(WIDE_PRODUCT)) u_alu (
      .is_mul (op_q == OP_MUL),
      .opa    (second),
      .opb    (top),
      .result (alu_res)
   );

   stack_eval_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (do_push),
      .pop        (do_pop),
      .merge      (do_merge),
      .push_data  (load_word),
      .merge_data (alu_res),
      .count      (count),
      .top        (top),
      .second     (second)
   );

   assign stack_ptr = count;
   assign stack_top = top;
endmodule

// File: rtl/stack_eval_chk.sv
module stack_eval_chk #(
   parameter int  DEPTH = 32,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          instr_valid,
   input logic          instr_ready,
   input logic [1:0]    instr_op,
   input logic [CW-1:0] stack_ptr,
   input logic          overflow,
   input logic          underflow
);
   logic take;
   assign take = instr_valid && instr_ready;

   a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      stack_ptr <= CW'(DEPTH));

   a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !instr_ready);

   a_r2_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_ready |=> instr_ready);

   a_r3_load_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (take && instr_op == 2'b00 && stack_ptr != CW'(DEPTH))
      |=> ##1 (stack_ptr == CW'($past(stack_ptr, 2) + CW'(1))));

   a_r7_full_load: assert property (@(posedge clk) disable iff (!rst_n)
      (take && instr_op == 2'b00 && stack_ptr == CW'(DEPTH))
      |=> ##1 (overflow && stack_ptr == CW'(DEPTH)));

   a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   a_r8_empty_store: assert property (@(posedge clk) disable iff (!rst_n)
      (take && instr_op == 2'b01 && stack_ptr == '0)
      |=> ##1 (underflow && stack_ptr == '0));

   a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);
endmodule

bind stack_eval stack_eval_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_ready (instr_ready),
   .instr_op    (instr_op),
   .stack_ptr   (stack_ptr),
   .overflow    (overflow),
   .underflow   (underflow)
);

// File: tb/stack_eval_test.sv
module stack_eval_test;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 32;
   localparam int WORDS  = 16;
   localparam int AW     = 4;
   localparam int CW     = 6;

   // op(2) addr(4) expected depth(6) expected top(16)
   localparam logic [27:0] VEC [8] = '{
      {2'b00, 4'd0, 6'd1, 16'd3},
      {2'b00, 4'd1, 6'd2, 16'd5},
      {2'b10, 4'd7, 6'd1, 16'd8},
      {2'b00, 4'd2, 6'd2, 16'd7},
      {2'b00, 4'd3, 6'd3, 16'd2},
      {2'b10, 4'd9, 6'd2, 16'd9},
      {2'b11, 4'd5, 6'd1, 16'd72},
      {2'b01, 4'd8, 6'd0, 16'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              instr_valid = 1'b0;
   logic              instr_ready;
   logic [1:0]        instr_op = 2'b00;
   logic [AW-1:0]     instr_addr = '0;
   logic              mem_we = 1'b0;
   logic [AW-1:0]     mem_addr = '0;
   logic [DATA_W-1:0] mem_wdata = '0;
   logic [DATA_W-1:0] mem_rdata;
   logic [CW-1:0]     stack_ptr;
   logic [DATA_W-1:0] stack_top;
   logic              overflow, underflow;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   stack_eval #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MEM_WORDS(WORDS)) uut (
      .clk(clk), .rst_n(rst_n),
      .instr_valid(instr_valid), .instr_ready(instr_ready),
      .instr_op(instr_op), .instr_addr(instr_addr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .stack_ptr(stack_ptr), .stack_top(stack_top),
      .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic mem_put(input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      mem_we = 1'b1; mem_addr = a; mem_wdata = d;
      @(negedge clk);
      mem_we = 1'b0;
   endtask

   task automatic mem_get(input logic [AW-1:0] a, output logic [DATA_W-1:0] d);
      @(negedge clk);
      mem_addr = a;
      #1 d = mem_rdata;
   endtask

   // drives on a falling edge, returns on the falling edge after the executing edge
   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input bit check_hs);
      @(negedge clk);
      instr_valid = 1'b1; instr_op = op; instr_addr = a;
      @(negedge clk);
      instr_valid = 1'b0;
      if (check_hs) chk("R2 busy after accept", 32'(instr_ready), 32'd0);
      @(negedge clk);
      if (check_hs) chk("R2 ready after two edges", 32'(instr_ready), 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] rd;

      // R1 reset state
      do_reset();
      chk("R1 depth", 32'(stack_ptr), 32'd0);
      chk("R1 top", 32'(stack_top), 32'd0);
      chk("R1 overflow", 32'(overflow), 32'd0);
      chk("R1 underflow", 32'(underflow), 32'd0);
      chk("R1 ready", 32'(instr_ready), 32'd1);

      // R10 port write and read-back
      mem_put(4'd0, 16'd3);
      mem_put(4'd1, 16'd5);
      mem_put(4'd2, 16'd7);
      mem_put(4'd3, 16'd2);
      mem_get(4'd2, rd);
      chk("R10 port read", 32'(rd), 32'd7);

      // R9 postfix program, one step per table row (R3 R4 R5 R6)
      for (int i = 0; i < 8; i++) begin
         issue(VEC[i][27:26], VEC[i][25:22], i == 0);
         chk("R9 depth step", 32'(stack_ptr), 32'(VEC[i][21:16]));
         chk("R9 top step", 32'(stack_top), 32'(VEC[i][15:0]));
      end
      mem_get(4'd8, rd);
      chk("R9 R4 stored result", 32'(rd), 32'd72);

      // R5 add wraps modulo 2^16
      mem_put(4'd4, 16'hFFFF);
      mem_put(4'd5, 16'h0002);
      issue(2'b00, 4'd4, 1'b0);
      issue(2'b00, 4'd5, 1'b0);
      issue(2'b10, 4'd15, 1'b0);
      chk("R5 wrapped sum", 32'(stack_top), 32'h0001);
      issue(2'b01, 4'd9, 1'b0);
      mem_get(4'd9, rd);
      chk("R4 store of sum", 32'(rd), 32'h0001);

      // R6 multiply keeps low bits: 0x0101*0x0300 = 0x30300
      mem_put(4'd6, 16'h0101);
      mem_put(4'd7, 16'h0300);
      issue(2'b00, 4'd6, 1'b0);
      issue(2'b00, 4'd7, 1'b0);
      issue(2'b11, 4'd0, 1'b0);
      chk("R6 low product", 32'(stack_top), 32'h0300);
      chk("R6 depth", 32'(stack_ptr), 32'd1);
      issue(2'b01, 4'd10, 1'b0);
      chk("R4 depth after store", 32'(stack_ptr), 32'd0);

      // R8 store on empty stack leaves memory and depth
      mem_put(4'd11, 16'h1234);
      issue(2'b01, 4'd11, 1'b0);
      chk("R8 underflow set", 32'(underflow), 32'd1);
      chk("R8 depth kept", 32'(stack_ptr), 32'd0);
      mem_get(4'd11, rd);
      chk("R8 memory untouched", 32'(rd), 32'h1234);
      issue(2'b00, 4'd0, 1'b0);
      chk("R8 underflow sticky", 32'(underflow), 32'd1);

      // R8 add with one entry
      do_reset();
      chk("R1 flags cleared", 32'({overflow, underflow}), 32'd0);
      issue(2'b00, 4'd2, 1'b0);
      issue(2'b10, 4'd0, 1'b0);
      chk("R8 add underflow", 32'(underflow), 32'd1);
      chk("R8 depth after add", 32'(stack_ptr), 32'd1);
      chk("R8 top after add", 32'(stack_top), 32'd7);

      // R7 load on full stack
      do_reset();
      mem_put(4'd12, 16'h00AA);
      mem_put(4'd13, 16'h0BBB);
      for (int i = 0; i < DEPTH; i++) issue(2'b00, 4'd12, 1'b0);
      chk("R7 depth full", 32'(stack_ptr), 32'(DEPTH));
      chk("R7 no overflow yet", 32'(overflow), 32'd0);
      issue(2'b00, 4'd13, 1'b0);
      chk("R7 overflow set", 32'(overflow), 32'd1);
      chk("R7 depth kept", 32'(stack_ptr), 32'(DEPTH));
      chk("R7 top kept", 32'(stack_top), 32'h00AA);
      issue(2'b01, 4'd14, 1'b0);
      chk("R7 overflow sticky", 32'(overflow), 32'd1);
      chk("R4 depth below full", 32'(stack_ptr), 32'(DEPTH - 1));

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule